// File: doc/BRIEF.md
# Receive Free-Buffer Pool Allocator

This block hands host buffer pointers to packets arriving on the receive side. The host keeps two pools of free buffers topped up: one of small buffers and one of big buffers. Each pool is a ring with its own push port. A per-channel table is indexed directly by the incoming virtual-channel number. For each channel it holds a pool-select bit, the channel's current buffer, whether that buffer is still held, and how many cells the packet has used so far.

Cell descriptors enter on a valid/ready stream. Each one carries a channel number and start-of-packet and end-of-packet markers. For every accepted cell, one result leaves on a second valid/ready stream. At the start of a packet the block pops the oldest pointer from the pool that the channel selects and records it as the channel's buffer. Later cells of the same packet report that buffer again. Nothing is drawn ahead of a packet start. Channel 0 carries maintenance cells, and every one of its cells is a complete one-cell packet.

Back-pressure rules: a cell is taken when `cell_valid` and `cell_ready` are both high. `cell_ready` is low only while a result is held and `alloc_ready` is low. While `alloc_valid` is high and `alloc_ready` is low, every result field stays unchanged. Each pool push is taken when `*_push_valid` and `*_push_ready` are both high.

Top module: `rxa_alloc`

## Requirements
- R1: After reset, `alloc_valid` is 0, `cell_ready` is 1, both push-ready outputs are 1, both empty flags are 1, and every channel's pool-select bit is 0.
- R2: A cell with `cell_sop`=1 on a channel whose select bit is 0 pops the small ring; a select bit of 1 pops the big ring. The oldest pointer pushed is popped first. The result shows `alloc_has_buf`=1, `alloc_drop`=0, and that pointer in `alloc_ptr`.
- R3: A cell with `cell_sop`=0 on a channel that holds a buffer reports that same pointer with `alloc_has_buf`=1 and pops nothing. Each channel number addresses its own state, and channels do not disturb one another.
- R4: If the selected ring is empty at a packet start, the result shows `alloc_drop`=1, `alloc_has_buf`=0 and `alloc_ptr`=0, and no ring changes. A non-start cell on a channel without a buffer shows `alloc_has_buf`=0, `alloc_drop`=0 and `alloc_ptr`=0.
- R5: A cell with `cell_eop`=1 gives `alloc_last`=1 and releases the channel's buffer. A pointer stays in its ring until a packet start takes it, so the next start receives the next pointer in ring order.
- R6: Every cell on channel 0 is treated as a packet start and ends its packet: it allocates as in R2 or R4 and always shows `alloc_last`=1.
- R7: A ring holding its full depth of pointers drives its push-ready low, and a push offered then is discarded and never handed out. The empty flag is 1 exactly when the ring holds no pointer.
- R8: A packet may use at most `MAX_CELLS` cells (default 1366, which covers 64K bytes). The packet's start cell counts as 1. A non-start cell that would be cell `MAX_CELLS`+1 gives `alloc_oversize`=1, `alloc_last`=1 and `alloc_has_buf`=0, and releases the buffer.
- R9: While `alloc_valid`=1 and `alloc_ready`=0, `cell_ready` is 0 and all result fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write the pool-select bit of `cfg_ch` |
| cfg_ch | input | CH_W | Channel being configured |
| cfg_big | input | 1 | Select value: 0 small ring, 1 big ring |
| sm_push_valid | input | 1 | Small ring push request |
| sm_push_ptr | input | PTR_W | Pointer pushed to the small ring |
| sm_push_ready | output | 1 | Small ring can accept a push |
| bg_push_valid | input | 1 | Big ring push request |
| bg_push_ptr | input | PTR_W | Pointer pushed to the big ring |
| bg_push_ready | output | 1 | Big ring can accept a push |
| sm_empty | output | 1 | Small ring holds no pointer |
| bg_empty | output | 1 | Big ring holds no pointer |
| cell_valid | input | 1 | Cell descriptor valid |
| cell_ready | output | 1 | Cell descriptor accepted |
| cell_ch | input | CH_W | Virtual-channel number of the cell |
| cell_sop | input | 1 | Cell starts a packet |
| cell_eop | input | 1 | Cell ends a packet |
| alloc_valid | output | 1 | Result valid |
| alloc_ready | input | 1 | Result consumer ready |
| alloc_ch | output | CH_W | Channel of the result |
| alloc_ptr | output | PTR_W | Buffer pointer, 0 when none |
| alloc_has_buf | output | 1 | Cell has a buffer |
| alloc_drop | output | 1 | Packet start found its ring empty |
| alloc_oversize | output | 1 | Packet exceeded `MAX_CELLS` cells |
| alloc_last | output | 1 | Packet ends with this cell |

## Verification
The bench aims at the empty-ring packet start. A design that popped anyway would hand out stale pointers, and one that left the channel marked busy would report a buffer on the later cells. It fills a ring to its depth and pushes once more, then drains the ring. A design that overwrote the oldest slot would reveal itself through the wrong pointer order. It sends channel-0 cells without start markers, which a design would mishandle by leaving them as continuations. It also runs a packet one cell past the length limit, where an off-by-one comparison would flag the wrong cell. Results are held under random back-pressure, so a result that changes while stalled is caught.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  typedef enum logic { POOL_SMALL = 1'b0, POOL_BIG = 1'b1 } pool_e;
  localparam int NPOOL = 2;
endpackage

// File: rtl/rxa_ring.sv
module rxa_ring #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  output logic         push_ready,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_idx, rd_idx;
  logic [CW-1:0] fill;
  logic          do_push, do_pop;

  assign push_ready = (fill != CW'(DEPTH));
  assign empty      = (fill == '0);
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && !empty;
  assign pop_data   = mem[rd_idx];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] v);
    return (v == AW'(DEPTH - 1)) ? '0 : v + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_idx <= bump(wr_idx);
      if (do_pop)  rd_idx <= bump(rd_idx);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/rxa_chan_tbl.sv
module rxa_chan_tbl #(
  parameter int CH_W  = 10,
  parameter int PTR_W = 32,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CH_W-1:0]  cfg_ch,
  input  logic             cfg_big,
  input  logic [CH_W-1:0]  rd_ch,
  output logic             rd_big,
  output logic             rd_has,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] rd_cnt,
  input  logic             upd_we,
  input  logic [CH_W-1:0]  upd_ch,
  input  logic             upd_has,
  input  logic [PTR_W-1:0] upd_ptr,
  input  logic [CNT_W-1:0] upd_cnt
);
  localparam int NCH = 1 << CH_W;

  logic             sel_big [NCH];
  logic             held    [NCH];
  logic [PTR_W-1:0] bufp    [NCH];
  logic [CNT_W-1:0] ncell   [NCH];

  assign rd_big = sel_big[rd_ch];
  assign rd_has = held[rd_ch];
  assign rd_ptr = bufp[rd_ch];
  assign rd_cnt = ncell[rd_ch];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) sel_big[i] <= 1'b0;
    end else if (cfg_we) begin
      sel_big[cfg_ch] <= cfg_big;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        held[i]  <= 1'b0;
        ncell[i] <= '0;
      end
    end else if (upd_we) begin
      held[upd_ch]  <= upd_has;
      ncell[upd_ch] <= upd_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_we) bufp[upd_ch] <= upd_ptr;
  end
endmodule

// File: rtl/rxa_alloc.sv
module rxa_alloc
  import rxa_pkg::*;
#(
  parameter int CH_W        = 10,
  parameter int PTR_W       = 32,
  parameter int SMALL_DEPTH = 8,
  parameter int BIG_DEPTH   = 8,
  parameter int MAX_CELLS   = 1366
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CH_W-1:0]  cfg_ch,
  input  logic             cfg_big,
  input  logic             sm_push_valid,
  input  logic [PTR_W-1:0] sm_push_ptr,
  output logic             sm_push_ready,
  input  logic             bg_push_valid,
  input  logic [PTR_W-1:0] bg_push_ptr,
  output logic             bg_push_ready,
  output logic             sm_empty,
  output logic             bg_empty,
  input  logic             cell_valid,
  output logic             cell_ready,
  input  logic [CH_W-1:0]  cell_ch,
  input  logic             cell_sop,
  input  logic             cell_eop,
  output logic             alloc_valid,
  input  logic             alloc_ready,
  output logic [CH_W-1:0]  alloc_ch,
  output logic [PTR_W-1:0] alloc_ptr,
  output logic             alloc_has_buf,
  output logic             alloc_drop,
  output logic             alloc_oversize,
  output logic             alloc_last
);
  localparam int CNT_W = $clog2(MAX_CELLS + 1);

  logic             r_pv    [NPOOL];
  logic [PTR_W-1:0] r_pd    [NPOOL];
  logic             r_pr    [NPOOL];
  logic             r_pop   [NPOOL];
  logic [PTR_W-1:0] r_head  [NPOOL];
  logic             r_empty [NPOOL];

  assign r_pv[POOL_SMALL] = sm_push_valid;
  assign r_pd[POOL_SMALL] = sm_push_ptr;
  assign r_pv[POOL_BIG]   = bg_push_valid;
  assign r_pd[POOL_BIG]   = bg_push_ptr;
  assign sm_push_ready    = r_pr[POOL_SMALL];
  assign bg_push_ready    = r_pr[POOL_BIG];
  assign sm_empty         = r_empty[POOL_SMALL];
  assign bg_empty         = r_empty[POOL_BIG];

  logic             accept, is_new, sel, sel_empty, over;
  logic             rd_big, rd_has;
  logic [PTR_W-1:0] rd_ptr, ptr_now;
  logic [CNT_W-1:0] rd_cnt, cnt_now;
  logic             has_now, last_now;

  for (genvar g = 0; g < NPOOL; g++) begin : g_pool
    localparam int D = (g == int'(POOL_SMALL)) ? SMALL_DEPTH : BIG_DEPTH;
    assign r_pop[g] = accept && is_new && (sel == g[0]) && !r_empty[g];
    rxa_ring #(.DEPTH(D), .W(PTR_W)) u_ring (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (r_pv[g]),
      .push_data  (r_pd[g]),
      .push_ready (r_pr[g]),
      .pop        (r_pop[g]),
      .pop_data   (r_head[g]),
      .empty      (r_empty[g])
    );
  end

  rxa_chan_tbl #(.CH_W(CH_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_ch  (cfg_ch),
    .cfg_big (cfg_big),
    .rd_ch   (cell_ch),
    .rd_big  (rd_big),
    .rd_has  (rd_has),
    .rd_ptr  (rd_ptr),
    .rd_cnt  (rd_cnt),
    .upd_we  (accept),
    .upd_ch  (cell_ch),
    .upd_has (has_now && !last_now),
    .upd_ptr (ptr_now),
    .upd_cnt (cnt_now)
  );

  assign cell_ready = !alloc_valid || alloc_ready;
  assign accept     = cell_valid && cell_ready;

  always_comb begin
    is_new    = cell_sop || (cell_ch == '0);
    sel       = rd_big;
    sel_empty = r_empty[sel];
    over      = !is_new && rd_has && (rd_cnt >= CNT_W'(MAX_CELLS));
    if (is_new) begin
      has_now = !sel_empty;
      ptr_now = r_head[sel];
      cnt_now = CNT_W'(1);
    end else begin
      has_now = rd_has && !over;
      ptr_now = rd_ptr;
      cnt_now = (rd_cnt >= CNT_W'(MAX_CELLS)) ? rd_cnt : rd_cnt + CNT_W'(1);
    end
    last_now = cell_eop || (cell_ch == '0) || over;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_valid    <= 1'b0;
      alloc_ch       <= '0;
      alloc_ptr      <= '0;
      alloc_has_buf  <= 1'b0;
      alloc_drop     <= 1'b0;
      alloc_oversize <= 1'b0;
      alloc_last     <= 1'b0;
    end else if (accept) begin
      alloc_valid    <= 1'b1;
      alloc_ch       <= cell_ch;
      alloc_ptr      <= has_now ? ptr_now : '0;
      alloc_has_buf  <= has_now;
      alloc_drop     <= is_new && sel_empty;
      alloc_oversize <= over;
      alloc_last     <= last_now;
    end else if (alloc_ready) begin
      alloc_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/rxa_alloc_chk.sv
module rxa_alloc_chk #(
  parameter int CH_W  = 10,
  parameter int PTR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sm_push_ready,
  input logic             bg_push_ready,
  input logic             sm_empty,
  input logic             bg_empty,
  input logic             cell_ready,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [CH_W-1:0]  alloc_ch,
  input logic [PTR_W-1:0] alloc_ptr,
  input logic             alloc_has_buf,
  input logic             alloc_drop,
  input logic             alloc_oversize,
  input logic             alloc_last
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && !alloc_ready |=> alloc_valid && $stable(alloc_ch) && $stable(alloc_ptr)
      && $stable(alloc_has_buf) && $stable(alloc_drop) && $stable(alloc_last));
  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && !alloc_ready |-> !cell_ready);
  // R4
  drop_nobuf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_drop |-> !alloc_has_buf && alloc_ptr == '0);
  // R6
  oam_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ch == '0 |-> alloc_last && !alloc_oversize);
  // R8
  over_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_oversize |-> alloc_last && !alloc_has_buf && !alloc_drop);
  // R7
  full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sm_push_ready |-> !sm_empty) and (!bg_push_ready |-> !bg_empty));
endmodule

bind rxa_alloc rxa_alloc_chk #(.CH_W(CH_W), .PTR_W(PTR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sm_push_ready  (sm_push_ready),
  .bg_push_ready  (bg_push_ready),
  .sm_empty       (sm_empty),
  .bg_empty       (bg_empty),
  .cell_ready     (cell_ready),
  .alloc_valid    (alloc_valid),
  .alloc_ready    (alloc_ready),
  .alloc_ch       (alloc_ch),
  .alloc_ptr      (alloc_ptr),
  .alloc_has_buf  (alloc_has_buf),
  .alloc_drop     (alloc_drop),
  .alloc_oversize (alloc_oversize),
  .alloc_last     (alloc_last)
);

// File: tb/tb_rxa_alloc.sv
module tb_rxa_alloc;
  localparam int CH_W = 10;
  localparam int PTR_W = 32;
  localparam int DEP = 8;
  localparam int MAXC = 1366;
  localparam int NCH = 1 << CH_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_big = 1'b0;
  logic [CH_W-1:0] cfg_ch = '0;
  logic sm_push_valid = 1'b0, bg_push_valid = 1'b0;
  logic [PTR_W-1:0] sm_push_ptr = '0, bg_push_ptr = '0;
  logic sm_push_ready, bg_push_ready, sm_empty, bg_empty;
  logic cell_valid = 1'b0, cell_sop = 1'b0, cell_eop = 1'b0;
  logic [CH_W-1:0] cell_ch = '0;
  logic cell_ready, alloc_valid, alloc_has_buf, alloc_drop, alloc_oversize, alloc_last;
  logic alloc_ready = 1'b0;
  logic [CH_W-1:0] alloc_ch;
  logic [PTR_W-1:0] alloc_ptr;

  always #2ns clk = ~clk;

  rxa_alloc #(.CH_W(CH_W), .PTR_W(PTR_W), .SMALL_DEPTH(DEP), .BIG_DEPTH(DEP),
              .MAX_CELLS(MAXC)) dut (.*);

  int errors = 0, checks = 0;
  logic [PTR_W-1:0] sq[$], bq[$];
  logic m_big [NCH];
  logic m_has [NCH];
  logic [PTR_W-1:0] m_ptr [NCH];
  int m_cnt [NCH];
  int next_ptr = 32'h1000;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_cfg(input int ch, input bit big);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CH_W'(ch); cfg_big = big;
    @(negedge clk);
    cfg_we = 1'b0;
    m_big[ch] = big;
  endtask

  task automatic do_push(input bit big);
    bit exp_rdy;
    logic [PTR_W-1:0] p;
    p = PTR_W'(next_ptr);
    next_ptr += 16;
    @(negedge clk);
    exp_rdy = big ? (bq.size() < DEP) : (sq.size() < DEP);
    if (big) begin bg_push_valid = 1'b1; bg_push_ptr = p; end
    else     begin sm_push_valid = 1'b1; sm_push_ptr = p; end
    #1;
    chk((big ? bg_push_ready : sm_push_ready) == exp_rdy, "R7", "push_ready",
        64'(big ? bg_push_ready : sm_push_ready), 64'(exp_rdy));
    @(negedge clk);
    sm_push_valid = 1'b0; bg_push_valid = 1'b0;
    if (exp_rdy) begin
      if (big) bq.push_back(p); else sq.push_back(p);
    end
    chk(sm_empty == (sq.size() == 0) && bg_empty == (bq.size() == 0), "R7", "empty flags",
        64'({sm_empty, bg_empty}), 64'({sq.size() == 0, bq.size() == 0}));
  endtask

  task automatic send(input int ch, input bit sop, input bit eop, input int stall);
    bit nw, e_has, e_drop, e_over, e_last;
    logic [PTR_W-1:0] e_ptr;
    logic [127:0] got, cap;
    string tag;
    nw = sop || ch == 0;
    e_drop = 0; e_over = 0; e_ptr = '0; e_has = 0;
    if (nw) begin
      if ((m_big[ch] ? bq.size() : sq.size()) == 0) e_drop = 1;
      else begin
        e_has = 1;
        e_ptr = m_big[ch] ? bq.pop_front() : sq.pop_front();
      end
      m_cnt[ch] = 1;
    end else if (m_has[ch] && m_cnt[ch] >= MAXC) begin
      e_over = 1;
    end else begin
      e_has = m_has[ch];
      e_ptr = e_has ? m_ptr[ch] : '0;
      m_cnt[ch]++;
    end
    e_last = eop || ch == 0 || e_over;
    m_has[ch] = e_has && !e_last;
    if (e_has) m_ptr[ch] = e_ptr;
    tag = (ch == 0) ? "R6" : e_over ? "R8" : e_drop ? "R4" : eop ? "R5" : nw ? "R2" : "R3";

    @(negedge clk);
    cell_valid = 1'b1; cell_ch = CH_W'(ch); cell_sop = sop; cell_eop = eop;
    while (!cell_ready) @(negedge clk);
    @(negedge clk);
    cell_valid = 1'b0;
    cap = {alloc_valid, 22'(alloc_ch), alloc_ptr, alloc_has_buf, alloc_drop, alloc_oversize, alloc_last};
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      got = {alloc_valid, 22'(alloc_ch), alloc_ptr, alloc_has_buf, alloc_drop, alloc_oversize, alloc_last};
      chk(got == cap && !cell_ready, "R9", "held result", got[63:0], cap[63:0]);
    end
    got = {alloc_valid, 22'(alloc_ch), alloc_ptr, alloc_has_buf, alloc_drop, alloc_oversize, alloc_last};
    chk(got == {1'b1, 22'(ch), e_ptr, e_has, e_drop, e_over, e_last}, tag, "result",
        got[63:0], {22'(ch), e_ptr, e_has, e_drop, e_over, e_last});
    alloc_ready = 1'b1;
    @(negedge clk);
    alloc_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      m_big[i] = 0; m_has[i] = 0; m_ptr[i] = '0; m_cnt[i] = 0;
    end
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!alloc_valid && cell_ready && sm_push_ready && bg_push_ready && sm_empty && bg_empty,
        "R1", "reset outputs",
        64'({alloc_valid, cell_ready, sm_push_ready, bg_push_ready, sm_empty, bg_empty}),
        64'(6'b011111));

    // R4 empty ring at start, then continuation without buffer
    send(3, 1, 0, 0);
    send(3, 0, 0, 0);
    send(3, 0, 1, 0);
    // R7 fill small ring past depth, R2 drain in order
    for (int i = 0; i < DEP + 2; i++) do_push(0);
    for (int i = 0; i < 3; i++) do_push(1);
    do_cfg(7, 1);
    send(7, 1, 0, 2);
    send(3, 1, 0, 1);
    send(7, 0, 0, 0);
    send(3, 0, 1, 3);
    send(7, 0, 1, 0);
    send(3, 1, 1, 0);
    // R6 channel 0 cells without start marker
    send(0, 0, 0, 1);
    send(0, 0, 1, 0);
    send(0, 1, 0, 0);
    // R8 oversize run on channel 5
    do_push(0);
    send(5, 1, 0, 0);
    for (int i = 1; i < MAXC; i++) send(5, 0, 0, 0);
    send(5, 0, 0, 0);
    send(5, 0, 1, 0);

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op, ch;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1: do_push(1'($urandom_range(0, 1)));
        2:    do_cfg(int'($urandom_range(1, 6)), 1'($urandom_range(0, 1)));
        default: begin
          ch = int'($urandom_range(0, 7));
          if (ch == 7) ch = NCH - 1;
          send(ch, $urandom_range(0, 9) < 4, $urandom_range(0, 9) < 3,
               int'($urandom_range(0, 3)));
        end
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule